// File: doc/BRIEF.md
# Trailing Zero Count Execution Unit

This unit sits in the integer datapath of a processor core and counts how many consecutive zero bits a source operand holds, starting from bit 0 and stopping at the first set bit. The operand width is chosen per operation as 16, 32 or 64 bits. Bits above the chosen width take no part in the count. When no bit is set inside the chosen width, the count equals the operand width. The unit also produces a carry flag and a zero flag for the flag register.

A second, legacy scan mode follows the older forward bit-scan rule. When the source is zero, the unit passes the incoming destination value through unchanged instead of returning the width. The flags follow a different rule in this mode.

Operations enter with `in_valid`. The result, the flags and `out_valid` appear on registered outputs one clock later and stay put until the next accepted operation.

Top module: `tz_count_unit`

## Requirements
- R1: In count mode (`in_legacy`=0) with a nonzero source inside the selected width, `out_result` equals the number of zero bits below the lowest set bit, zero-extended to 64 bits.
- R2: In count mode, when the source is zero inside the selected width, `out_result` equals that width: 16, 32 or 64.
- R3: `in_size` encodes the width as 2'b00 = 16 bits, 2'b01 = 32 bits, and 2'b10 or 2'b11 = 64 bits. Source bits at or above the selected width do not affect any output.
- R4: In count mode, `out_cf` is 1 exactly when the source is zero inside the selected width.
- R5: In count mode, `out_zf` is 1 exactly when the count is zero, which means source bit 0 is set.
- R6: In legacy mode (`in_legacy`=1) with a zero source inside the selected width, `out_result` equals `in_old_dest` exactly as presented, all 64 bits.
- R7: In legacy mode, `out_zf` is 1 exactly when the source is zero inside the selected width, and `out_cf` is always 0. With a nonzero source, `out_result` is the count of R1.
- R8: `out_of`, `out_sf`, `out_pf` and `out_af` have no defined meaning and are always driven 0.
- R9: `out_valid` is 1 in the cycle after a clock edge that sees `in_valid`=1, and 0 otherwise. A synchronous active-low reset clears `out_valid`, `out_result` and all flags.
- R10: After an edge with `in_valid`=0, `out_result`, `out_cf` and `out_zf` keep their previous values.
- R11: Whenever a count is returned, it is at most 64, so only the low 7 bits of `out_result` can be nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present on the inputs this cycle |
| in_src | input | 64 | Source operand |
| in_size | input | 2 | Operand width select (R3 encoding) |
| in_legacy | input | 1 | 1 selects legacy scan mode, 0 selects count mode |
| in_old_dest | input | 64 | Current destination value, returned on a zero source in legacy mode |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | 64 | Count or passed-through destination |
| out_cf | output | 1 | Carry flag |
| out_zf | output | 1 | Zero flag |
| out_of | output | 1 | Overflow flag, always 0 |
| out_sf | output | 1 | Sign flag, always 0 |
| out_pf | output | 1 | Parity flag, always 0 |
| out_af | output | 1 | Auxiliary-carry flag, always 0 |

## Verification
The assertions take for granted that `rst_n` is held low across at least one rising edge before the first operation. They also assume that `in_size`, `in_legacy` and `in_src` are stable around the clock edge, because the search tree result is checked against the masked source in the same cycle. The bench changes every input only on the falling edge, starts with a reset pulse, and repeats the reset in mid-run with `in_valid` held high. Stimulus covers all four size codes and both modes. It includes junk bits above the selected width and bubbles with `in_valid` low.

// File: rtl/tzc_pkg.sv
// Package: shared operand-size encoding for the trailing zero count unit.
// Assumes the full datapath width is a multiple of 4, so the quarter and
// half widths are whole numbers.
package tzc_pkg;

    // Operand width select; both upper codes mean the full width.
    typedef enum logic [1:0] {
        SZ_QUARTER = 2'b00,
        SZ_HALF    = 2'b01,
        SZ_FULL    = 2'b10,
        SZ_FULL_B  = 2'b11
    } size_sel_e;

    // Number of operand bits selected by a size code, for datapath width full_w.
    function automatic int unsigned op_bits(input size_sel_e s, input int unsigned full_w);
        case (s)
            SZ_QUARTER: op_bits = full_w / 4;
            SZ_HALF:    op_bits = full_w / 2;
            default:    op_bits = full_w;
        endcase
    endfunction

endpackage

// File: rtl/tzc_leaf4.sv
// Leaf encoder: finds the lowest set bit of a 4-bit group.
// Assumes nothing about the input; idx is 3 when the group is all zero,
// and a parent must qualify it with any.
module tzc_leaf4 (
    input  logic [3:0] nib,
    output logic       any,
    output logic [1:0] idx
);

    // Priority pick of the lowest set bit within the group.
    always_comb begin
        any = |nib;
        if (nib[0])      idx = 2'd0;
        else if (nib[1]) idx = 2'd1;
        else if (nib[2]) idx = 2'd2;
        else             idx = 2'd3;
    end

endmodule

// File: rtl/tzc_prio_tree.sv
// Log-depth lowest-set-bit search. Leaves are 4-bit encoders. Pairs of
// nodes are merged level by level, so the tree is a heap with the root at
// index 0. Assumes VEC_W is a power of two and at least 8.
module tzc_prio_tree #(
    parameter int unsigned VEC_W = 64,
    localparam int unsigned IDX_W = $clog2(VEC_W)
) (
    input  logic [VEC_W-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    localparam int unsigned LEAVES = VEC_W / 4;
    localparam int unsigned LEVELS = $clog2(LEAVES);
    localparam int unsigned NODES  = 2 * LEAVES - 1;

    logic [NODES-1:0] node_any;
    logic [IDX_W-1:0] node_idx [NODES];

    // Leaf row: one encoder for each nibble, stored at the bottom of the heap.
    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        logic [1:0] leaf_idx;
        tzc_leaf4 u_leaf (
            .nib (vec[4*g +: 4]),
            .any (node_any[LEAVES-1+g]),
            .idx (leaf_idx)
        );
        assign node_idx[LEAVES-1+g] = IDX_W'(leaf_idx);
    end

    // Merge rows: the lower child wins. Otherwise the upper child's index is
    // offset by the span of the lower child, which sets bit lvl+1.
    for (genvar lvl = 1; lvl <= LEVELS; lvl++) begin : g_lvl
        localparam int unsigned BASE  = (LEAVES >> lvl) - 1;
        localparam int unsigned CBASE = (LEAVES >> (lvl - 1)) - 1;
        for (genvar n = 0; n < (LEAVES >> lvl); n++) begin : g_node
            assign node_any[BASE+n] = node_any[CBASE+2*n] | node_any[CBASE+2*n+1];
            assign node_idx[BASE+n] = node_any[CBASE+2*n]
                                    ? node_idx[CBASE+2*n]
                                    : (node_idx[CBASE+2*n+1] | IDX_W'(1 << (lvl + 1)));
        end
    end

    assign any = node_any[0];
    assign idx = node_idx[0];

endmodule

// File: rtl/tzc_size_mask.sv
// Operand-size decode: turns the size code into a bit mask over the
// datapath and the width as a count value. Assumes DATA_W is a multiple of 4.
module tzc_size_mask #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned CNT_W = $clog2(DATA_W) + 1
) (
    input  logic [1:0]        size_sel,
    output logic [DATA_W-1:0] mask,
    output logic [CNT_W-1:0]  width
);

    import tzc_pkg::*;

    int unsigned sel_bits;

    // Width decode, then a thermometer mask with ones below the width.
    always_comb begin
        sel_bits = op_bits(size_sel_e'(size_sel), DATA_W);
        width    = CNT_W'(sel_bits);
        for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (i < int'(sel_bits));
        end
    end

endmodule

// File: rtl/tz_count_unit.sv
// Trailing zero count execution unit. It masks the source to the selected
// width, runs the lowest-set-bit tree, applies the count-mode or
// legacy-scan-mode result and flag rules, and registers everything with a
// single valid bit. Assumes inputs are stable around the rising edge. The
// reset is synchronous and active-low.
module tz_count_unit #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned IDX_W = $clog2(DATA_W),
    localparam int unsigned CNT_W = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src,
    input  logic [1:0]        in_size,
    input  logic              in_legacy,
    input  logic [DATA_W-1:0] in_old_dest,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic              out_cf,
    output logic              out_zf,
    output logic              out_of,
    output logic              out_sf,
    output logic              out_pf,
    output logic              out_af
);

    import tzc_pkg::*;

    logic [DATA_W-1:0] size_mask;
    logic [CNT_W-1:0]  size_width;
    logic [DATA_W-1:0] src_masked;
    logic              tree_any;
    logic [IDX_W-1:0]  tree_idx;
    logic              src_zero;
    logic [CNT_W-1:0]  count;
    logic [DATA_W-1:0] res_d;
    logic              cf_d;
    logic              zf_d;
    logic              legacy_q;
    logic [1:0]        size_q;

    tzc_size_mask #(.DATA_W(DATA_W)) u_size (
        .size_sel (in_size),
        .mask     (size_mask),
        .width    (size_width)
    );

    assign src_masked = in_src & size_mask;

    tzc_prio_tree #(.VEC_W(DATA_W)) u_tree (
        .vec (src_masked),
        .any (tree_any),
        .idx (tree_idx)
    );

    // Result and flag selection for count mode and legacy scan mode.
    always_comb begin
        src_zero = ~tree_any;
        count    = src_zero ? size_width : {1'b0, tree_idx};
        if (in_legacy) begin
            res_d = src_zero ? in_old_dest : DATA_W'(count);
            cf_d  = 1'b0;
            zf_d  = src_zero;
        end else begin
            res_d = DATA_W'(count);
            cf_d  = src_zero;
            zf_d  = (count == '0);
        end
    end

    // Output register: loads on in_valid and holds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_cf     <= 1'b0;
            out_zf     <= 1'b0;
            legacy_q   <= 1'b0;
            size_q     <= 2'b00;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= res_d;
                out_cf     <= cf_d;
                out_zf     <= zf_d;
                legacy_q   <= in_legacy;
                size_q     <= in_size;
            end
        end
    end

    // Flags with no defined meaning are tied low.
    assign out_of = 1'b0;
    assign out_sf = 1'b0;
    assign out_pf = 1'b0;
    assign out_af = 1'b0;

    // R1: the tree index points at a set bit with only zeros below it.
    p_first_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tree_any |-> (src_masked[tree_idx] &&
                      ((src_masked & ((DATA_W'(1) << tree_idx) - DATA_W'(1))) == '0)));

    // R2: the tree reports no set bit only when the masked source is empty.
    p_zero_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tree_any |-> (src_masked == '0));

    // R2: a carry in count mode comes with a result equal to the stored width.
    p_cf_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !legacy_q && out_cf) |->
            (out_result == DATA_W'(op_bits(size_sel_e'(size_q), DATA_W))));

    // R4: carry and zero flags are never both set in count mode.
    p_flag_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !legacy_q) |-> !(out_cf && out_zf));

    // R7: legacy mode never reports carry.
    p_legacy_cf_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && legacy_q) |-> !out_cf);

    // R9: out_valid follows in_valid by one cycle.
    p_valid_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10: an idle cycle leaves the result and flags untouched.
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_cf) && $stable(out_zf)));

    // R11: any count result fits the count range.
    p_count_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !legacy_q) |-> (out_result <= DATA_W'(DATA_W)));

endmodule

// File: tb/test_tz_count_unit.sv
// Self-checking bench: a loop-based reference model is checked against the
// registered outputs once per clock.
module test_tz_count_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [63:0] in_src;
    logic [1:0]  in_size;
    logic        in_legacy;
    logic [63:0] in_old_dest;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_cf, out_zf, out_of, out_sf, out_pf, out_af;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic        exp_valid;
    logic [63:0] exp_result;
    logic        exp_cf, exp_zf;

    always #(CLK_P/2) clk = ~clk;

    tz_count_unit i_tz_count_unit (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_src (in_src),
        .in_size (in_size), .in_legacy (in_legacy), .in_old_dest (in_old_dest),
        .out_valid (out_valid), .out_result (out_result), .out_cf (out_cf),
        .out_zf (out_zf), .out_of (out_of), .out_sf (out_sf), .out_pf (out_pf),
        .out_af (out_af)
    );

    // Record one check and report it if it fails.
    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: a bit-by-bit walk from bit 0.
    task automatic ref_model(input logic [63:0] src, input logic [1:0] sz,
                             input logic leg, input logic [63:0] old);
        int w = (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
        int n = 0;
        while (n < w && src[n] == 1'b0) n++;
        if (leg) begin
            exp_result = (n == w) ? old : 64'(n);
            exp_cf     = 1'b0;
            exp_zf     = (n == w);
        end else begin
            exp_result = 64'(n);
            exp_cf     = (n == w);
            exp_zf     = (n == 0);
        end
    endtask

    // Drive one cycle from a falling edge, update the model, compare at the next falling edge.
    task automatic cycle(input logic v, input logic [63:0] src, input logic [1:0] sz,
                         input logic leg, input logic [63:0] old, input string tag);
        in_valid = v; in_src = src; in_size = sz; in_legacy = leg; in_old_dest = old;
        @(posedge clk);
        if (!rst_n) begin
            exp_valid = 1'b0; exp_result = '0; exp_cf = 1'b0; exp_zf = 1'b0;
        end else if (v) begin
            exp_valid = 1'b1;
            ref_model(src, sz, leg, old);
        end else begin
            exp_valid = 1'b0;
        end
        @(negedge clk);
        chk(tag, "out_valid", 64'(out_valid), 64'(exp_valid));
        chk(tag, "result",    out_result, exp_result);
        chk(tag, "cf/zf",     64'({out_cf, out_zf}), 64'({exp_cf, exp_zf}));
        chk("R8", "of/sf/pf/af", 64'({out_of, out_sf, out_pf, out_af}), 64'(0));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL R9 watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; in_src = '0; in_size = 2'b00; in_legacy = 1'b0; in_old_dest = '0;
        @(negedge clk);
        cycle(1'b1, 64'h1, 2'b10, 1'b0, '0, "R9 reset");
        cycle(1'b0, '0, 2'b00, 1'b0, '0, "R9 reset");
        rst_n = 1'b1;

        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 2; m++) begin
                int w = (s == 0) ? 16 : (s == 1) ? 32 : 64;
                logic [63:0] junk;
                junk = (w == 64) ? 64'h0 : (~64'h0 << w);
                // R2/R6: zero source inside the width, junk above it (R3).
                cycle(1'b1, junk, 2'(s), m[0], 64'hDEAD_BEEF_0123_4567, m ? "R6" : "R2");
                cycle(1'b1, '0,   2'(s), m[0], 64'hFFFF_0000_FFFF_0000, m ? "R7" : "R4");
                // R1/R7: single set bit at every position inside the width.
                for (int p = 0; p < w; p++) begin
                    cycle(1'b1, (64'h1 << p) | junk, 2'(s), m[0], rnd64(), m ? "R7" : "R1");
                end
                // R5: all ones gives a zero count.
                cycle(1'b1, ~64'h0, 2'(s), m[0], rnd64(), "R5");
                // R10: idle cycles with new inputs leave outputs held.
                cycle(1'b0, 64'h8000, 2'(s), m[0], rnd64(), "R10");
                cycle(1'b0, '0, 2'(s), m[0], rnd64(), "R10");
                // R11: random patterns with varied trailing zeros and bubbles.
                for (int k = 0; k < 40; k++) begin
                    cycle(($urandom % 4) != 0, rnd64() << ($urandom % 64), 2'(s), m[0],
                          rnd64(), "R11");
                end
            end
        end

        // R9: a mid-run reset with in_valid high clears the outputs.
        rst_n = 1'b0;
        cycle(1'b1, 64'h10, 2'b10, 1'b0, '0, "R9");
        rst_n = 1'b1;
        cycle(1'b1, 64'h10, 2'b10, 1'b0, '0, "R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule